// File: doc/BRIEF.md
# Latched/Registered Bidirectional Bus Transceiver

This block is a non-inverting data path between two 18-bit ports, A and B, for use inside a chip. Each port is split into an input bus, an output bus and a drive-enable. Data can flow from A to B and from B to A. Each direction has its own storage cell and its own four controls: an active-low output enable, a latch enable, a direction clock and an active-low clock enable. The storage cell of a direction works in one of two ways. It is a transparent latch while its latch enable is high. It is a clock-enabled rising-edge register while its latch enable is low.

The direction clocks are ordinary inputs that the system clock samples. A rising edge is seen when a direction clock is sampled low at one system clock edge and high at the next. The drive-enable of a port is the inverse of the output enable of the direction that targets that port. A flag is raised when both ports are driven at the same time. A pad-level wrapper can build real tri-state pins from each port's output bus and drive-enable.

Top module: `dual_path_xcvr`

## Requirements
- R1: After the asynchronous reset (rst_ni low), both storage cells hold all zeros. With the latch enables low, a_out_o and b_out_o read 0.
- R2: b_drive_o is 1 exactly when ab_oe_ni is 0, and a_drive_o is 1 exactly when ba_oe_ni is 0. Both follow their enable within the same cycle. When a drive-enable is 0, the port is not driven.
- R3: While a latch enable is 1, the destination output equals the source input bit for bit, without inversion and within the same cycle, whatever the clock and clock enable of that direction are doing.
- R4: Take a direction whose latch enable is 0 and whose clock enable is 0. If its clock is sampled 0 at one system clock edge and 1 at the next, the source value present at that second edge is stored. It is shown on the destination output from that edge on.
- R5: While the latch enable is 0 and no rising direction-clock edge is seen, the stored value does not change, even if the direction clock is held at 1 or at 0 and the source changes.
- R6: While a clock enable is 1, rising edges of that direction's clock are ignored and the stored value is held.
- R7: When a latch enable goes from 1 to 0, the cell keeps the source value sampled at the last system clock edge at which the latch enable was 1.
- R8: The B-to-A path behaves like the A-to-B path, using its own controls. Storage in either direction works while that direction's output is disabled. A value captured with the drive disabled is driven once the drive is enabled.
- R9: collide_o is 1 exactly when a_drive_o and b_drive_o are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_in_i | input | 18 | Value seen on port A |
| a_out_o | output | 18 | Value driven onto port A (B-to-A path) |
| a_drive_o | output | 1 | Port A drive-enable |
| b_in_i | input | 18 | Value seen on port B |
| b_out_o | output | 18 | Value driven onto port B (A-to-B path) |
| b_drive_o | output | 1 | Port B drive-enable |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cp_i | input | 1 | A-to-B direction clock |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cp_i | input | 1 | B-to-A direction clock |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |
| collide_o | output | 1 | Both ports driven at once |

## Verification
The drive-enables, the collision flag and the transparent path have no register on the way, so they are due in the same cycle as the stimulus. A capture takes one system clock edge, the edge at which the direction clock is first sampled high. The latch-enable fall keeps the value from the edge before the fall, so both results are due right after an edge. The bench changes inputs just after the rising edge and compares every output against its behavioural model at the falling edge. The model state is advanced at each rising edge. The directed checks read the outputs one step after the edge that should have caused the change, so every result is sampled in the cycle it is due.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_W = 18;
  localparam int unsigned N_DIR = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic cp;
    logic ce_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_i,
  output logic rise_o
);
  logic cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cp_q <= 1'b0;
    else         cp_q <= cp_i;
  end

  assign rise_o = cp_i & ~cp_q;
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         le_i,
  input  logic         ce_ni,
  input  logic         rise_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] store_q;
  logic         load;

  assign load = le_i | (~ce_ni & rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (load) store_q <= src_i;
  end

  // transparent while le_i, stored value otherwise
  assign out_o = le_i ? src_i : store_q;

  assert_le_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (store_q == $past(src_i)));
  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !ce_ni && rise_i) |=> (store_q == $past(src_i)));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i) |=> $stable(store_q));
  assert_ce_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && ce_ni) |=> $stable(store_q));
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_in_i,
  output logic [W-1:0] a_out_o,
  output logic         a_drive_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic         b_drive_o,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_cp_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_cp_i,
  input  logic         ba_ce_ni,
  output logic         collide_o
);
  // index 0: A to B, index 1: B to A
  dir_ctrl_t    ctl [N_DIR];
  logic [W-1:0] src [N_DIR];
  logic [W-1:0] dst [N_DIR];
  logic [N_DIR-1:0] drv;

  assign ctl[0] = '{oe_n: ab_oe_ni, le: ab_le_i, cp: ab_cp_i, ce_n: ab_ce_ni};
  assign ctl[1] = '{oe_n: ba_oe_ni, le: ba_le_i, cp: ba_cp_i, ce_n: ba_ce_ni};
  assign src[0] = a_in_i;
  assign src[1] = b_in_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic rise;

    xcvr_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cp_i   (ctl[d].cp),
      .rise_o (rise)
    );

    xcvr_store_cell #(.W(W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src[d]),
      .le_i   (ctl[d].le),
      .ce_ni  (ctl[d].ce_n),
      .rise_i (rise),
      .out_o  (dst[d])
    );

    assign drv[d] = ~ctl[d].oe_n;
  end

  assign b_out_o   = dst[0];
  assign b_drive_o = drv[0];
  assign a_out_o   = dst[1];
  assign a_drive_o = drv[1];
  assign collide_o = &drv;

  assert_collide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |-> (a_drive_o && b_drive_o));
  assert_b_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_drive_o |-> !ab_oe_ni);
  assert_a_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_drive_o |-> !ba_oe_ni);
endmodule

// File: tb/dual_path_xcvr_tb_top.sv
module dual_path_xcvr_tb_top;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive, collide;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_cp_ab = 1'b0, m_cp_ba = 1'b0;

  always #5 clk = ~clk;

  dual_path_xcvr #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_in_i(a_in), .a_out_o(a_out), .a_drive_o(a_drive),
    .b_in_i(b_in), .b_out_o(b_out), .b_drive_o(b_drive),
    .ab_oe_ni(ab_oe_n), .ab_le_i(ab_le), .ab_cp_i(ab_cp), .ab_ce_ni(ab_ce_n),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_cp_i(ba_cp), .ba_ce_ni(ba_ce_n),
    .collide_o(collide)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk(ab_le ? "R3 b_out" : "R4_R5 b_out", b_out, ab_le ? a_in : m_ab);
    chk(ba_le ? "R3 a_out" : "R8 a_out", a_out, ba_le ? b_in : m_ba);
    chk("R2 b_drive", W'(b_drive), W'(!ab_oe_n));
    chk("R2 a_drive", W'(a_drive), W'(!ba_oe_n));
    chk("R9 collide", W'(collide), W'(!ab_oe_n && !ba_oe_n));
  endtask

  task automatic model_step();
    if (ab_le) m_ab = a_in;
    else if (!ab_ce_n && ab_cp && !m_cp_ab) m_ab = a_in;
    if (ba_le) m_ba = b_in;
    else if (!ba_ce_n && ba_cp && !m_cp_ba) m_ba = b_in;
    m_cp_ab = ab_cp;
    m_cp_ba = ba_cp;
  endtask

  // inputs are set just after a rising edge; compare at the falling edge
  task automatic step();
    @(negedge clk);
    model_cmp();
    @(posedge clk);
    model_step();
    #1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: zero storage after reset
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    @(posedge clk); #1;

    // R2: drive-enables follow the active-low output enables
    ab_oe_n = 1'b0; #1;
    chk("R2 b_drive on", W'(b_drive), W'(1));
    chk("R2 a_drive off", W'(a_drive), W'(0));
    step();

    // R4: capture on direction-clock rise
    a_in = 18'h2A5C3; ab_cp = 1'b0; step();
    ab_cp = 1'b1; step();
    chk("R4 capture", b_out, 18'h2A5C3);
    // R5: clock held high, source changes
    a_in = 18'h15A3C; step(); step();
    chk("R5 hold high", b_out, 18'h2A5C3);
    ab_cp = 1'b0; step();
    chk("R5 hold low", b_out, 18'h2A5C3);

    // R6: clock enable high blocks a rise
    ab_ce_n = 1'b1; a_in = 18'h3FFFF; ab_cp = 1'b1; step();
    chk("R6 ce blocks", b_out, 18'h2A5C3);
    ab_cp = 1'b0; ab_ce_n = 1'b0; step();

    // R3: transparent regardless of clock activity
    ab_le = 1'b1; a_in = 18'h0F0F1; ab_ce_n = 1'b1; #1;
    chk("R3 transparent", b_out, 18'h0F0F1);
    ab_cp = 1'b1; step();
    a_in = 18'h30303; #1;
    chk("R3 follow", b_out, 18'h30303);
    step();

    // R7: latch enable fall keeps the last value sampled with it high
    ab_le = 1'b0; a_in = 18'h1BEEF; ab_cp = 1'b0; ab_ce_n = 1'b0; #1;
    chk("R7 le fall", b_out, 18'h30303);
    step();
    chk("R7 kept", b_out, 18'h30303);

    // R8: B-to-A capture while its drive is disabled
    ba_oe_n = 1'b1; b_in = 18'h2D00B; ba_cp = 1'b0; step();
    ba_cp = 1'b1; step();
    chk("R8 a_drive off", W'(a_drive), W'(0));
    ba_oe_n = 1'b0; #1;
    chk("R8 captured", a_out, 18'h2D00B);
    // R9: both drives on
    chk("R9 collide on", W'(collide), W'(1));
    step();
    ab_oe_n = 1'b1; #1;
    chk("R9 collide off", W'(collide), W'(0));
    ba_cp = 1'b0; step();

    // mixed random traffic compared against the model every cycle
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom) & MASK;
      b_in = W'($urandom) & MASK;
      {ab_oe_n, ab_cp, ab_ce_n} = 3'($urandom);
      {ba_oe_n, ba_cp, ba_ce_n} = 3'($urandom);
      ab_le = ($urandom % 4) == 0;
      ba_le = ($urandom % 4) == 0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule